// File: doc/BRIEF.md
# Read/Write Address-Phase Arbiter

This block sits between the read and write controllers of a bus master and the shared address channel of the bus. Each controller posts a request together with its address and transfer size. The arbiter picks one request, drives the bus request with that request's qualifiers, and holds them until the bus acknowledges the address. In the acknowledge cycle it returns a one-cycle grant to the controller that won.

When both channels ask at once, a write normally wins. A one-bit turn register records which channel was granted last. If that channel was the write channel and both channels are requesting again, the read goes first. This turn-passing rule means neither channel can be starved. If only one channel is requesting, it is served whatever the turn register holds. An address phase is never interrupted. Requests that arrive during a phase are considered only once that phase has ended.

Top module: `rw_addr_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released with no requests pending, `bus_req`, `rd_grant` and `wr_grant` are all 0.
- R2: If the bus is idle and exactly one channel requests, `bus_req` rises on the next cycle. The qualifiers come from that channel: `bus_rnw` = 1 for read and 0 for write, and `bus_addr`/`bus_size` are that channel's values. With no request, `bus_req` stays low.
- R3: If the bus is idle, both channels request, and the last granted channel was read (or nothing has been granted since reset), the write channel is selected (`bus_rnw` = 0).
- R4: If the bus is idle, both channels request, and the last granted channel was write, the read channel is selected (`bus_rnw` = 1).
- R5: While `bus_req` is high and no acknowledge has arrived, `bus_req`, `bus_addr`, `bus_rnw` and `bus_size` hold their values.
- R6: A grant is a single-cycle pulse raised in exactly the cycle where `bus_addr_ack` is high during an active phase. It goes only to the channel that owns the phase, and never to both channels at once.
- R7: `bus_req` is low on the cycle after an acknowledge. Requests that change during a phase do not alter that phase.
- R8: A channel whose request is pending while the other channel is served wins the next phase. No request waits longer than two phases plus their idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_req | input | 1 | Read controller request |
| rd_addr | input | ADDR_W | Read request address |
| rd_size | input | SIZE_W | Read request transfer size |
| wr_req | input | 1 | Write controller request |
| wr_addr | input | ADDR_W | Write request address |
| wr_size | input | SIZE_W | Write request transfer size |
| bus_addr_ack | input | 1 | Address acknowledge from the bus |
| bus_req | output | 1 | Bus request |
| bus_addr | output | ADDR_W | Address driven with the request |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_size | output | SIZE_W | Transfer size driven with the request |
| rd_grant | output | 1 | One-cycle grant to the read controller |
| wr_grant | output | 1 | One-cycle grant to the write controller |

## Verification
The assertions assume three things about the inputs. A controller keeps its request and its qualifiers steady until it is granted. It lowers the request at the clock edge that ends the grant cycle. The bus raises `bus_addr_ack` only while `bus_req` is high. The stimulus follows these rules. It raises requests only on idle channels, with fresh random addresses and sizes. It clears a request as soon as it sees the grant, and never raises the same channel again in that cycle. It drives the acknowledge only while its model holds an active phase, and forces the acknowledge after a bounded wait.

// File: rtl/rwa_pkg.sv
package rwa_pkg;
  typedef enum logic {CH_RD = 1'b0, CH_WR = 1'b1} rwa_ch_e;
endpackage

// File: rtl/rwa_rst_sync.sv
module rwa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/rwa_select.sv
module rwa_select
  import rwa_pkg::*;
(
  input  logic    rd_req,
  input  logic    wr_req,
  input  rwa_ch_e last_ch,
  output logic    any_req,
  output rwa_ch_e pick_ch
);
  always_comb begin
    any_req = rd_req | wr_req;
    if (rd_req && wr_req) pick_ch = (last_ch == CH_WR) ? CH_RD : CH_WR;
    else if (wr_req)      pick_ch = CH_WR;
    else                  pick_ch = CH_RD;
  end
endmodule

// File: rtl/rwa_turn.sv
module rwa_turn
  import rwa_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    upd_en,
  input  rwa_ch_e granted_ch,
  output rwa_ch_e last_ch
);
  rwa_ch_e last_q, last_d;

  always_comb last_d = upd_en ? granted_ch : last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= CH_RD;
    else        last_q <= last_d;
  end

  assign last_ch = last_q;
endmodule

// File: rtl/rwa_phase.sv
module rwa_phase
  import rwa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  rwa_ch_e           pick_ch,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SIZE_W-1:0] rd_size,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic              addr_ack,
  output logic              busy,
  output rwa_ch_e           owner_ch,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              done
);
  logic              busy_q, busy_d, load;
  rwa_ch_e           owner_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [SIZE_W-1:0] size_q, size_d;

  always_comb begin
    load   = !busy_q && start;
    busy_d = busy_q ? !addr_ack : start;
    addr_d = (pick_ch == CH_WR) ? wr_addr : rd_addr;
    size_d = (pick_ch == CH_WR) ? wr_size : rd_size;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= CH_RD;
      addr_q  <= '0;
      size_q  <= '0;
    end else if (load) begin
      owner_q <= pick_ch;
      addr_q  <= addr_d;
      size_q  <= size_d;
    end
  end

  assign busy     = busy_q;
  assign owner_ch = owner_q;
  assign addr_o   = addr_q;
  assign size_o   = size_q;
  assign done     = busy_q & addr_ack;
endmodule

// File: rtl/rw_addr_arbiter.sv
module rw_addr_arbiter
  import rwa_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 4,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SIZE_W-1:0] rd_size,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic              bus_addr_ack,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rnw,
  output logic [SIZE_W-1:0] bus_size,
  output logic              rd_grant,
  output logic              wr_grant
);
  logic    srst_n;
  logic    any_req, busy, done;
  rwa_ch_e pick_ch, last_ch, owner_ch;

  rwa_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  rwa_select u_sel (
    .rd_req(rd_req), .wr_req(wr_req), .last_ch(last_ch),
    .any_req(any_req), .pick_ch(pick_ch)
  );

  rwa_phase #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_phase (
    .clk(clk), .rst_n(srst_n), .start(any_req), .pick_ch(pick_ch),
    .rd_addr(rd_addr), .rd_size(rd_size), .wr_addr(wr_addr), .wr_size(wr_size),
    .addr_ack(bus_addr_ack), .busy(busy), .owner_ch(owner_ch),
    .addr_o(bus_addr), .size_o(bus_size), .done(done)
  );

  rwa_turn u_turn (
    .clk(clk), .rst_n(srst_n), .upd_en(done), .granted_ch(owner_ch),
    .last_ch(last_ch)
  );

  assign bus_req  = busy;
  assign bus_rnw  = (owner_ch == CH_RD);
  assign rd_grant = done && (owner_ch == CH_RD);
  assign wr_grant = done && (owner_ch == CH_WR);
endmodule

// File: rtl/rwa_checker.sv
module rwa_checker #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [SIZE_W-1:0] rd_size,
  input logic              wr_req,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [SIZE_W-1:0] wr_size,
  input logic              bus_addr_ack,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rnw,
  input logic [SIZE_W-1:0] bus_size,
  input logic              rd_grant,
  input logic              wr_grant
);
  logic last_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  last_wr_q <= 1'b0;
    else if (rd_grant || wr_grant) last_wr_q <= wr_grant;
  end

  AST_QUAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_addr_ack |=> bus_req && $stable(bus_addr) && $stable(bus_rnw) && $stable(bus_size)); // R5
  AST_GRANT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_grant || wr_grant) |-> bus_req && bus_addr_ack); // R6
  AST_ACK_GIVES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_addr_ack |-> (rd_grant || wr_grant)); // R6
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_grant, wr_grant})); // R6
  AST_GRANT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_grant |-> bus_rnw); // R6
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_addr_ack |=> !bus_req); // R7
  AST_SOLO_RD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && rd_req && !wr_req |=> bus_req && bus_rnw &&
      bus_addr == $past(rd_addr) && bus_size == $past(rd_size)); // R2
  AST_SOLO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && wr_req && !rd_req |=> bus_req && !bus_rnw &&
      bus_addr == $past(wr_addr) && bus_size == $past(wr_size)); // R2
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && !rd_req && !wr_req |=> !bus_req); // R2
  AST_WR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && rd_req && wr_req && !last_wr_q |=> bus_req && !bus_rnw); // R3
  AST_TURN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && rd_req && wr_req && last_wr_q |=> bus_req && bus_rnw); // R4
endmodule

bind rw_addr_arbiter rwa_checker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(srst_n),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
  .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size),
  .bus_addr_ack(bus_addr_ack), .bus_req(bus_req), .bus_addr(bus_addr),
  .bus_rnw(bus_rnw), .bus_size(bus_size),
  .rd_grant(rd_grant), .wr_grant(wr_grant)
);

// File: tb/sim_rw_addr_arbiter.sv
module sim_rw_addr_arbiter;
  localparam int ADDR_W   = 32;
  localparam int SIZE_W   = 4;
  localparam int ACK_MAX  = 6;
  localparam int WAIT_MAX = 24;

  logic              clk, rst_n;
  logic              rd_req, wr_req, bus_addr_ack;
  logic [ADDR_W-1:0] rd_addr, wr_addr, bus_addr;
  logic [SIZE_W-1:0] rd_size, wr_size, bus_size;
  logic              bus_req, bus_rnw, rd_grant, wr_grant;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model of the arbiter
  bit                m_busy = 0, m_owner = 0, m_last = 0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [SIZE_W-1:0] m_size = '0;
  string             m_tag = "R2";
  int                m_cnt = 0, rd_wait = 0, wr_wait = 0;

  rw_addr_arbiter #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_size(wr_size),
    .bus_addr_ack(bus_addr_ack), .bus_req(bus_req), .bus_addr(bus_addr),
    .bus_rnw(bus_rnw), .bus_size(bus_size),
    .rd_grant(rd_grant), .wr_grant(wr_grant)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit pick_owner(bit rq, bit wq, bit last);
    if (rq && wq) return !last;
    return wq;
  endfunction

  task automatic step(int p_rd, int p_wr, int p_ack);
    bit g_rd, g_wr;
    @(negedge clk);
    check("R2/R7 bus_req", bus_req, m_busy);
    if (m_busy) begin
      check({m_tag, " bus_rnw"}, bus_rnw, !m_owner);
      check("R5 bus_addr", bus_addr, m_addr);
      check("R5 bus_size", bus_size, m_size);
    end
    bus_addr_ack = m_busy && (($urandom_range(99, 0) < p_ack) || m_cnt >= ACK_MAX);
    #1;
    g_rd = bus_addr_ack && m_busy && !m_owner;
    g_wr = bus_addr_ack && m_busy && m_owner;
    check("R6 rd_grant", rd_grant, g_rd);
    check("R6 wr_grant", wr_grant, g_wr);
    if (g_rd) begin check("R8 read wait bound", rd_wait <= WAIT_MAX, 1); rd_req = 0; end
    if (g_wr) begin check("R8 write wait bound", wr_wait <= WAIT_MAX, 1); wr_req = 0; end
    if (!rd_req && !g_rd && $urandom_range(99, 0) < p_rd) begin
      rd_req = 1; rd_addr = $urandom; rd_size = SIZE_W'($urandom); rd_wait = 0;
    end
    if (!wr_req && !g_wr && $urandom_range(99, 0) < p_wr) begin
      wr_req = 1; wr_addr = $urandom; wr_size = SIZE_W'($urandom); wr_wait = 0;
    end
    if (m_busy) begin
      m_cnt++;
      if (bus_addr_ack) begin m_busy = 0; m_last = m_owner; end
    end else if (rd_req || wr_req) begin
      m_busy  = 1;
      m_cnt   = 0;
      m_owner = pick_owner(rd_req, wr_req, m_last);
      m_tag   = (rd_req && wr_req) ? (m_owner ? "R3" : "R4") : "R2";
      m_addr  = m_owner ? wr_addr : rd_addr;
      m_size  = m_owner ? wr_size : rd_size;
    end
    if (rd_req) rd_wait++;
    if (wr_req) wr_wait++;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; rd_req = 0; wr_req = 0; bus_addr_ack = 0;
    rd_addr = '0; wr_addr = '0; rd_size = '0; wr_size = '0;
    repeat (4) @(negedge clk);
    check("R1 bus_req in reset", bus_req, 0);
    check("R1 grants in reset", {rd_grant, wr_grant}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 bus_req after reset", bus_req, 0);
    check("R1 grants after reset", {rd_grant, wr_grant}, 0);
    // directed: constant contention, immediate acknowledge (R3 first, then R4 / R8 alternation)
    for (int i = 0; i < 40; i++) step(100, 100, 100);
    // directed: contention with slow acknowledge
    for (int i = 0; i < 60; i++) step(100, 100, 0);
    // read channel only, write idle (R2)
    for (int i = 0; i < 200; i++) step(60, 0, 40);
    // write channel only (R2)
    for (int i = 0; i < 200; i++) step(0, 60, 40);
    // constrained random mix
    for (int i = 0; i < 3000; i++) step(30, 30, 35);
    // drain
    for (int i = 0; i < 40; i++) step(0, 0, 100);
    check("R7 idle after drain", bus_req, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule